// File: doc/BRIEF.md
# 8-Bit Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit processor. It holds an accumulator, a temporary operand register and a five-flag status register. Each operation combines the accumulator with an 8-bit operand, or acts on the accumulator alone. The result goes back into the accumulator, except for compare. The flags are updated from that result.

The operations are add, add with carry, subtract, subtract with borrow, compare, AND, OR, XOR, complement, rotate left and right, increment, decrement, decimal adjust after addition, and a plain load of the operand. An operation is issued by holding `execEn` high for one clock with `opCode` and `operand` valid. The operand and operation code are captured at that edge into the operand stage. The accumulator and flags change at the following edge. Operations may be issued back to back: a carry produced by one operation is seen by the next.

Top module: `aluCore`

## Requirements
- R1: After reset the accumulator reads 00h and the flag byte reads 02h.
- R2: An operation issued with `execEn` high at clock edge k shows its accumulator and flag results after edge k+1. While `execEn` is low, nothing changes. Operation codes: 0 load, 1 add, 2 add with carry, 3 subtract, 4 subtract with borrow, 5 compare, 6 AND, 7 OR, 8 XOR, 9 complement, A rotate left, B rotate right, C increment, D decrement, E decimal adjust, F no operation.
- R3: The flag byte has sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bit 1 always reads 1, and bits 3 and 5 always read 0.
- R4: Add writes acc+operand. Add with carry also adds the carry flag. Carry is the carry out of bit 7, and auxiliary carry is the carry out of bit 3.
- R5: Subtract writes acc-operand. Subtract with borrow also subtracts the carry flag. Carry is set on a borrow out of bit 7. Auxiliary carry is set when the low nibble of acc is smaller than the low nibble of the operand plus the borrow-in.
- R6: Compare sets every flag exactly as subtract would, and leaves the accumulator unchanged.
- R7: AND sets auxiliary carry and clears carry. OR and XOR clear both auxiliary carry and carry.
- R8: Complement inverts every accumulator bit and leaves all flags unchanged.
- R9: Rotate left moves bit 7 into bit 0 and into carry. Rotate right moves bit 0 into bit 7 and into carry. Only the carry flag changes.
- R10: Increment and decrement change the accumulator by one and leave carry unchanged. Auxiliary carry is set when the low nibble was Fh (increment) or 0h (decrement).
- R11: Decimal adjust first adds 06h if the low nibble is above 9 or auxiliary carry is set. Auxiliary carry then becomes the carry out of bit 3 of that step. It next adds 60h if the intermediate high nibble is above 9, carry is set, or the first step carried out of bit 7. Carry is set when this second correction is applied and is otherwise kept.
- R12: Load copies the operand into the accumulator with flags unchanged. No operation changes nothing.
- R13: Every operation that writes sign, zero and parity derives them from its 8-bit result. Sign is bit 7, zero is set for a result of 00h, and parity is set for an even count of ones. This covers arithmetic, compare, logic, increment, decrement and decimal adjust.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| execEn | input | 1 | Issue strobe: capture opCode and operand this edge |
| opCode | input | 4 | Operation selector (see R2) |
| operand | input | 8 | Second operand |
| accOut | output | 8 | Accumulator contents |
| flagByte | output | 8 | Packed status flags (see R3) |

## Verification
A corrupted accumulator or flag bit stays visible at `accOut` or `flagByte` from the edge that writes it. Because carry and auxiliary carry feed later operations, a wrong flag also spreads into later results. The bench therefore compares both outputs one cycle after every issued operation, so a fault shows within two clocks of its cause. Idle cycles are checked for unchanged state. Chained sequences such as add-then-decimal-adjust and carry-propagating adds expose flags that are wrong but not yet visible.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 4'h0, OP_ADD = 4'h1, OP_ADC = 4'h2, OP_SUB = 4'h3,
    OP_SBB  = 4'h4, OP_CMP = 4'h5, OP_AND = 4'h6, OP_OR  = 4'h7,
    OP_XOR  = 4'h8, OP_CMA = 4'h9, OP_RLC = 4'hA, OP_RRC = 4'hB,
    OP_INR  = 4'hC, OP_DCR = 4'hD, OP_DAA = 4'hE, OP_NOP = 4'hF
  } aluOp_e;

  typedef enum logic [3:0] {
    FN_PASS, FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_NOT,
    FN_ROL, FN_ROR, FN_INC, FN_DEC, FN_DAA
  } aluFn_e;

  typedef struct packed {
    aluFn_e fn;
    logic   withCarry;
    logic   accWe;
    logic   szpWe;
    logic   acWe;
    logic   cyWe;
  } aluStrobe_t;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } aluFlags_t;
endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            execEn,
  input  logic [OP_W-1:0] opCode,
  output logic            stageValid,
  output logic [OP_W-1:0] stageOp,
  output aluStrobe_t      strobe
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      stageOp    <= OP_NOP;
    end else begin
      stageValid <= execEn;
      if (execEn) stageOp <= opCode;
    end
  end

  always_comb begin
    strobe = '{fn: FN_PASS, withCarry: 1'b0, accWe: 1'b0,
               szpWe: 1'b0, acWe: 1'b0, cyWe: 1'b0};
    if (stageValid) begin
      unique case (aluOp_e'(stageOp))
        OP_LOAD: begin strobe.fn = FN_PASS; strobe.accWe = 1'b1; end
        OP_ADD, OP_ADC: begin
          strobe.fn = FN_ADD; strobe.withCarry = (stageOp == OP_ADC);
          strobe.accWe = 1'b1; strobe.szpWe = 1'b1; strobe.acWe = 1'b1; strobe.cyWe = 1'b1;
        end
        OP_SUB, OP_SBB, OP_CMP: begin
          strobe.fn = FN_SUB; strobe.withCarry = (stageOp == OP_SBB);
          strobe.accWe = (stageOp != OP_CMP);
          strobe.szpWe = 1'b1; strobe.acWe = 1'b1; strobe.cyWe = 1'b1;
        end
        OP_AND, OP_OR, OP_XOR: begin
          strobe.fn = (stageOp == OP_AND) ? FN_AND : (stageOp == OP_OR) ? FN_OR : FN_XOR;
          strobe.accWe = 1'b1; strobe.szpWe = 1'b1; strobe.acWe = 1'b1; strobe.cyWe = 1'b1;
        end
        OP_CMA: begin strobe.fn = FN_NOT; strobe.accWe = 1'b1; end
        OP_RLC, OP_RRC: begin
          strobe.fn = (stageOp == OP_RLC) ? FN_ROL : FN_ROR;
          strobe.accWe = 1'b1; strobe.cyWe = 1'b1;
        end
        OP_INR, OP_DCR: begin
          strobe.fn = (stageOp == OP_INR) ? FN_INC : FN_DEC;
          strobe.accWe = 1'b1; strobe.szpWe = 1'b1; strobe.acWe = 1'b1;
        end
        OP_DAA: begin
          strobe.fn = FN_DAA;
          strobe.accWe = 1'b1; strobe.szpWe = 1'b1; strobe.acWe = 1'b1; strobe.cyWe = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              capture,
  input  logic [DATA_W-1:0] operandIn,
  input  aluStrobe_t        strobe,
  output logic [DATA_W-1:0] accQ,
  output aluFlags_t         flagQ
);
  logic [DATA_W-1:0] tempReg;
  logic [DATA_W-1:0] res;
  logic              nAc, nCy;
  logic              cIn;
  logic [DATA_W:0]   addWide, subWide, daaStage1;
  logic [NIB_W:0]    addLow, subLow, daaLow;
  logic              lowFix, hiFix;

  assign cIn     = strobe.withCarry & flagQ.cy;
  assign addWide = {1'b0, accQ} + {1'b0, tempReg} + {{DATA_W{1'b0}}, cIn};
  assign subWide = {1'b0, accQ} - {1'b0, tempReg} - {{DATA_W{1'b0}}, cIn};
  assign addLow  = {1'b0, accQ[NIB_W-1:0]} + {1'b0, tempReg[NIB_W-1:0]} + {{NIB_W{1'b0}}, cIn};
  assign subLow  = {1'b0, accQ[NIB_W-1:0]} - {1'b0, tempReg[NIB_W-1:0]} - {{NIB_W{1'b0}}, cIn};

  // decimal adjust: low-nibble correction, then high-nibble correction
  assign lowFix    = (accQ[NIB_W-1:0] > 4'd9) | flagQ.ac;
  assign daaLow    = {1'b0, accQ[NIB_W-1:0]} + (lowFix ? 5'd6 : 5'd0);
  assign daaStage1 = {1'b0, accQ} + (lowFix ? 9'h006 : 9'h000);
  assign hiFix     = (daaStage1[DATA_W-1:NIB_W] > 4'd9) | flagQ.cy | daaStage1[DATA_W];

  always_comb begin
    res = accQ;
    nAc = flagQ.ac;
    nCy = flagQ.cy;
    unique case (strobe.fn)
      FN_PASS: res = tempReg;
      FN_ADD:  begin res = addWide[DATA_W-1:0]; nCy = addWide[DATA_W]; nAc = addLow[NIB_W]; end
      FN_SUB:  begin res = subWide[DATA_W-1:0]; nCy = subWide[DATA_W]; nAc = subLow[NIB_W]; end
      FN_AND:  begin res = accQ & tempReg; nAc = 1'b1; nCy = 1'b0; end
      FN_OR:   begin res = accQ | tempReg; nAc = 1'b0; nCy = 1'b0; end
      FN_XOR:  begin res = accQ ^ tempReg; nAc = 1'b0; nCy = 1'b0; end
      FN_NOT:  res = ~accQ;
      FN_ROL:  begin res = {accQ[DATA_W-2:0], accQ[DATA_W-1]}; nCy = accQ[DATA_W-1]; end
      FN_ROR:  begin res = {accQ[0], accQ[DATA_W-1:1]}; nCy = accQ[0]; end
      FN_INC:  begin res = accQ + 1'b1; nAc = &accQ[NIB_W-1:0]; end
      FN_DEC:  begin res = accQ - 1'b1; nAc = ~|accQ[NIB_W-1:0]; end
      FN_DAA:  begin
        res = daaStage1[DATA_W-1:0] + (hiFix ? 8'h60 : 8'h00);
        nAc = daaLow[NIB_W];
        nCy = flagQ.cy | hiFix;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempReg <= '0;
      accQ    <= '0;
      flagQ   <= '0;
    end else begin
      if (capture)      tempReg  <= operandIn;
      if (strobe.accWe) accQ     <= res;
      if (strobe.szpWe) begin
        flagQ.s <= res[DATA_W-1];
        flagQ.z <= (res == '0);
        flagQ.p <= ~^res;
      end
      if (strobe.acWe)  flagQ.ac <= nAc;
      if (strobe.cyWe)  flagQ.cy <= nCy;
    end
  end
endmodule

// File: rtl/aluCore.sv
module aluCore
  import aluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              execEn,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] flagByte
);
  aluStrobe_t      strobe;
  aluFlags_t       flags;
  logic            stageValid;
  logic [OP_W-1:0] stageOp;

  aluControl u_ctrl (
    .clk(clk), .rstN(rstN), .execEn(execEn), .opCode(opCode),
    .stageValid(stageValid), .stageOp(stageOp), .strobe(strobe)
  );

  aluDatapath u_dp (
    .clk(clk), .rstN(rstN), .capture(execEn), .operandIn(operand),
    .strobe(strobe), .accQ(accOut), .flagQ(flags)
  );

  assign flagByte = {flags.s, flags.z, 1'b0, flags.ac, 1'b0, flags.p, 1'b1, flags.cy};
endmodule

// File: rtl/aluCoreChecker.sv
module aluCoreChecker
  import aluPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              stageValid,
  input logic [OP_W-1:0]   stageOp,
  input logic [DATA_W-1:0] accOut,
  input logic [DATA_W-1:0] flagByte
);
  logic szpOp;
  assign szpOp = stageValid &&
    (stageOp inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_AND, OP_OR, OP_XOR,
                     OP_INR, OP_DCR, OP_DAA});

  assert_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    flagByte[1] && !flagByte[3] && !flagByte[5]);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stageValid |=> $stable(accOut) && $stable(flagByte));

  assert_cmp_keeps_acc_R6: assert property (@(posedge clk) disable iff (!rstN)
    stageValid && stageOp == OP_CMP |=> $stable(accOut));

  assert_and_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    stageValid && stageOp == OP_AND |=> flagByte[4] && !flagByte[0]);

  assert_complement_R8: assert property (@(posedge clk) disable iff (!rstN)
    stageValid && stageOp == OP_CMA |=> accOut == ~$past(accOut) && $stable(flagByte));

  assert_rotate_left_R9: assert property (@(posedge clk) disable iff (!rstN)
    stageValid && stageOp == OP_RLC |=>
      accOut == {$past(accOut[DATA_W-2:0]), $past(accOut[DATA_W-1])} &&
      flagByte[0] == $past(accOut[DATA_W-1]));

  assert_incdec_carry_R10: assert property (@(posedge clk) disable iff (!rstN)
    stageValid && (stageOp == OP_INR || stageOp == OP_DCR) |=> flagByte[0] == $past(flagByte[0]));

  assert_szp_from_result_R13: assert property (@(posedge clk) disable iff (!rstN)
    szpOp |=> flagByte[7] == accOut[7] && flagByte[6] == (accOut == '0) && flagByte[2] == ~^accOut);
endmodule

bind aluCore aluCoreChecker u_chk (
  .clk(clk), .rstN(rstN), .stageValid(stageValid), .stageOp(stageOp),
  .accOut(accOut), .flagByte(flagByte)
);

// File: tb/sim_aluCore.sv
module sim_aluCore;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, execEn;
  logic [3:0] opCode;
  logic [7:0] operand;
  wire  [7:0] accOut, flagByte;

  aluCore u0 (.clk(clk), .rstN(rstN), .execEn(execEn), .opCode(opCode),
              .operand(operand), .accOut(accOut), .flagByte(flagByte));

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] mAcc;
  logic mS, mZ, mAc, mP, mCy;

  function automatic logic [7:0] packFlags();
    return {mS, mZ, 1'b0, mAc, 1'b0, mP, 1'b1, mCy};
  endfunction

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'h0, 4'hF: return "R12";
      4'h1, 4'h2: return "R4";
      4'h3, 4'h4: return "R5";
      4'h5: return "R6";
      4'h6, 4'h7, 4'h8: return "R7";
      4'h9: return "R8";
      4'hA, 4'hB: return "R9";
      4'hC, 4'hD: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setSzp(input logic [7:0] r);
    mS = r[7]; mZ = (r == 8'h00); mP = ~^r;
  endtask

  task automatic model(input logic [3:0] op, input logic [7:0] b);
    logic [8:0] w; logic c; logic [4:0] lo; logic lf, hf; logic [8:0] s1; logic [7:0] r;
    c = 1'b0;
    case (op)
      4'h0: mAcc = b;
      4'h1, 4'h2: begin
        c = (op == 4'h2) ? mCy : 1'b0;
        w = mAcc + b + c; lo = mAcc[3:0] + b[3:0] + c;
        mAcc = w[7:0]; mCy = w[8]; mAc = lo[4]; setSzp(mAcc);
      end
      4'h3, 4'h4, 4'h5: begin
        c = (op == 4'h4) ? mCy : 1'b0;
        w = {1'b0, mAcc} - {1'b0, b} - c;
        mAc = ({1'b0, mAcc[3:0]} < ({1'b0, b[3:0]} + c));
        mCy = ({1'b0, mAcc} < ({1'b0, b} + c));
        setSzp(w[7:0]);
        if (op != 4'h5) mAcc = w[7:0];
      end
      4'h6: begin mAcc = mAcc & b; mAc = 1'b1; mCy = 1'b0; setSzp(mAcc); end
      4'h7: begin mAcc = mAcc | b; mAc = 1'b0; mCy = 1'b0; setSzp(mAcc); end
      4'h8: begin mAcc = mAcc ^ b; mAc = 1'b0; mCy = 1'b0; setSzp(mAcc); end
      4'h9: mAcc = ~mAcc;
      4'hA: begin mCy = mAcc[7]; mAcc = {mAcc[6:0], mAcc[7]}; end
      4'hB: begin mCy = mAcc[0]; mAcc = {mAcc[0], mAcc[7:1]}; end
      4'hC: begin mAc = (mAcc[3:0] == 4'hF); mAcc = mAcc + 8'd1; setSzp(mAcc); end
      4'hD: begin mAc = (mAcc[3:0] == 4'h0); mAcc = mAcc - 8'd1; setSzp(mAcc); end
      4'hE: begin
        lf = (mAcc[3:0] > 4'd9) || mAc;
        lo = mAcc[3:0] + (lf ? 5'd6 : 5'd0);
        s1 = mAcc + (lf ? 9'd6 : 9'd0);
        hf = (s1[7:4] > 4'd9) || mCy || s1[8];
        r  = s1[7:0] + (hf ? 8'h60 : 8'h00);
        mAc = lo[4]; mCy = mCy | hf; mAcc = r; setSzp(r);
      end
      default: ;
    endcase
  endtask

  task automatic runOp(input logic [3:0] op, input logic [7:0] b);
    @(negedge clk); opCode = op; operand = b; execEn = 1'b1;
    @(negedge clk); execEn = 1'b0; opCode = $urandom; operand = $urandom;
    @(negedge clk);
    model(op, b);
    check(tagOf(op), accOut, mAcc);
    check({tagOf(op), " R13 flags"}, flagByte, packFlags());
    check("R3 fixed bits", flagByte & 8'h2A, 8'h02);
  endtask

  task automatic idleCheck(input int n);
    logic [7:0] a, f;
    a = accOut; f = flagByte;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); opCode = $urandom; operand = $urandom;
    end
    @(negedge clk);
    check("R2 idle acc", accOut, a);
    check("R2 idle flags", flagByte, f);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R2 actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0a1b);
    rstN = 1'b0; execEn = 1'b0; opCode = 4'hF; operand = 8'h00;
    mAcc = 8'h00; {mS, mZ, mAc, mP, mCy} = 5'b0;
    repeat (3) @(negedge clk);
    check("R1 reset acc", accOut, 8'h00);
    check("R1 reset flags", flagByte, 8'h02);
    rstN = 1'b1;
    idleCheck(4);

    // BCD subtraction via complement and decimal adjust: 96 - 38 = 58
    runOp(4'h0, 8'h99); runOp(4'h3, 8'h38); runOp(4'hC, 8'h00);
    runOp(4'h1, 8'h96); runOp(4'hE, 8'h00);
    check("R11 bcd example acc", accOut, 8'h58);
    check("R11 bcd example carry", flagByte & 8'h01, 8'h01);

    // carry chain and add-with-carry
    runOp(4'h0, 8'hFF); runOp(4'h1, 8'h01);
    check("R4 wrap flags", flagByte, 8'h57);
    runOp(4'h2, 8'h00);
    check("R4 adc carry in", accOut, 8'h01);
    // borrow chain
    runOp(4'h3, 8'h02); runOp(4'h4, 8'h00);
    // compare keeps accumulator
    runOp(4'h0, 8'h40); runOp(4'h5, 8'h40);
    check("R6 cmp acc kept", accOut, 8'h40);
    runOp(4'h5, 8'h41);
    // logic, complement, rotates, inc/dec boundaries, nop
    runOp(4'h6, 8'h0F); runOp(4'h7, 8'hA0); runOp(4'h8, 8'hFF);
    runOp(4'h9, 8'h00); runOp(4'hA, 8'h00); runOp(4'hB, 8'h00);
    runOp(4'h0, 8'h0F); runOp(4'hC, 8'h00); runOp(4'h0, 8'h00); runOp(4'hD, 8'h00);
    runOp(4'hF, 8'h55);
    runOp(4'h0, 8'h99); runOp(4'h1, 8'h01); runOp(4'hE, 8'h00);
    check("R11 99+01 adjust", accOut, 8'h00);
    idleCheck(3);

    for (int i = 0; i < 600; i++) begin
      runOp(4'($urandom_range(0, 15)), 8'($urandom));
      if (($urandom % 16) == 0) idleCheck(2);
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule